// File: doc/BRIEF.md
# Triggered Delayed One-Shot Pulse Generator

This block emits a single output pulse a programmable time after a trigger. Two down-counters are chained. The first is the delay channel. Once armed, it waits for a trigger, loads the delay value, and counts down one step per count tick. When it reaches zero it raises a one-cycle completion strobe and goes back to waiting. The terminal event also starts the second channel, the width channel. That channel loads the width value, drives the output active for that many ticks, and then stops.

A trigger is either a selected edge on an external input, which passes through a synchronizer first, or a software kick. The same start strobe arms both channels, and the same stop strobe freezes both. When stopped, both counter values stay visible and the output keeps its level. The delay, the width and the output polarity can only be written while the block is stopped. An output-enable control can replace the pulse with a software-chosen level.

Top module: `oneshot_delay_pulse`

## Requirements
- R1: After reset, `running`, `done_stb`, `delay_cnt` and `width_cnt` are 0. With `out_en`=1 and `sw_level`=0, `pulse_out` is 0.
- R2: `edge_sel` picks the trigger edge: 00 is falling, 01 is rising, 10 is both edges, and 11 behaves as falling. The input passes through two synchronizer flops and one edge flop. A change applied before clock edge 1 loads the delay counter at clock edge 3.
- R3: A `sw_kick` sampled while armed and idle loads `cfg_delay` into `delay_cnt`. The counter then drops by one on each clock edge where `tick` is high, and holds where `tick` is low.
- R4: `done_stb` is high for exactly one clock, D+1 ticks after the load (D is the delay value). The delay channel then waits for a new trigger and does not reload by itself.
- R5: On the delay terminal edge, the width channel loads `cfg_width` (W). The output goes active on the next tick and stays active for W ticks. W=0 gives no pulse.
- R6: A trigger is ignored while the delay or width countdown is in progress, and also when it lands on the delay terminal edge or while the block is stopped.
- R7: Start sets `running` to 1, waits for a trigger, and returns the pulse to inactive. Stop clears `running` and freezes both counters and the output level at the stop edge. If start and stop arrive together, stop wins.
- R8: While `running` is 1, `cfg_we` has no effect on the delay, the width or the polarity. `edge_sel` stays live.
- R9: `cfg_act_low`=0 gives an active-high pulse and `cfg_act_low`=1 an active-low pulse. The idle output is the inverse of the active level.
- R10: With `out_en`=0, `pulse_out` follows `sw_level`, whatever the pulse state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable tick |
| trig_in | input | 1 | External trigger, asynchronous |
| edge_sel | input | 2 | Trigger edge select |
| start_stb | input | 1 | One-cycle arm strobe |
| stop_stb | input | 1 | One-cycle stop strobe |
| sw_kick | input | 1 | Software trigger of the delay channel |
| cfg_we | input | 1 | Configuration write, honoured only when stopped |
| cfg_delay | input | CNT_W | Delay value |
| cfg_width | input | CNT_W | Width value |
| cfg_act_low | input | 1 | Output polarity, 1 = active low |
| out_en | input | 1 | 1 = pulse logic drives the output |
| sw_level | input | 1 | Output level used when out_en is 0 |
| done_stb | output | 1 | Delay completion strobe |
| running | output | 1 | Channels armed |
| delay_cnt | output | CNT_W | Delay counter value |
| width_cnt | output | CNT_W | Width counter value |
| pulse_out | output | 1 | Output pin level |

## Verification
The risky coincidence is a trigger that lands on the same clock edge as the delay terminal, when one channel is handing over to the other. The bench provokes it by placing a software kick exactly on that edge, and again one edge later while the width channel has just launched. The run passes only if exactly one completion strobe appears and the pulse start and length match the values computed for a single shot. A stop issued in the middle of a pulse is judged the same way: the frozen counters and the held output level must stay unchanged until the block is re-armed.

// File: rtl/osp_pkg.sv
// Package: shared types for the triggered delayed one-shot generator.
// Assumes: the edge-select field is two bits wide.
package osp_pkg;
    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/osp_trig_sync.sv
// Trigger synchronizer and edge detector.
// Brings trig_in into the clock domain through STAGES flops. A further flop
// holds the previous level. One-cycle trig_evt on the selected edge.
// Assumes: STAGES >= 2; the reserved select code behaves as falling.
module osp_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_in,
    input  osp_pkg::edge_sel_e  edge_sel,
    output logic                trig_evt
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise_w;
    logic              fall_w;

    // Shift the raw input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], trig_in};
    end

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // Pick the qualifying edge according to the select code
    always_comb begin
        rise_w = sync_q[LAST] & ~prev_q;
        fall_w = ~sync_q[LAST] & prev_q;
        unique case (edge_sel)
            osp_pkg::EDGE_RISE: trig_evt = rise_w;
            osp_pkg::EDGE_BOTH: trig_evt = rise_w | fall_w;
            default:            trig_evt = fall_w;
        endcase
    end

    // R2
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && edge_sel != osp_pkg::EDGE_BOTH) |=> !trig_evt);
endmodule

// File: rtl/osp_delay_chan.sv
// Delay channel: waits for a trigger while enabled, loads load_val, counts
// down on ticks. Its terminal event (count zero on a tick) is output at once
// for the width channel and is also registered as done_stb.
// Assumes: arm has priority; blocked holds off triggers while the width
// channel is busy.
module osp_delay_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             arm,
    input  logic             tick,
    input  logic             trig_req,
    input  logic             blocked,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             term,
    output logic             done_stb
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic             accept_w;

    // Terminal event and trigger acceptance
    always_comb begin
        term     = en && busy_q && tick && (cnt_q == '0);
        accept_w = en && trig_req && !busy_q && !blocked;
    end

    // Counter state: arm, load on trigger, count down, stop at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (arm) begin
            busy_q <= 1'b0;
        end else if (accept_w) begin
            cnt_q  <= load_val;
            busy_q <= 1'b1;
        end else if (en && busy_q && tick) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Register the completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= term;
    end

    assign cnt      = cnt_q;
    assign busy     = busy_q;
    assign done_stb = done_q;

    // R3
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tick) |=> $stable(cnt_q));
    // R4
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
endmodule

// File: rtl/osp_width_chan.sv
// Width channel: launched by the delay terminal event, loads load_val.
// It spends one tick reaching the active phase, then W ticks active, then
// stops with the count at zero. A width of zero never goes active.
// Assumes: launch cannot arrive while busy (triggers are blocked then).
module osp_width_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             arm,
    input  logic             tick,
    input  logic             launch,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             active
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             act_q;

    // Launch, activation tick, countdown and end of pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            act_q  <= 1'b0;
        end else if (arm) begin
            busy_q <= 1'b0;
            act_q  <= 1'b0;
        end else if (en && launch) begin
            cnt_q  <= load_val;
            busy_q <= (load_val != '0);
            act_q  <= 1'b0;
        end else if (en && busy_q && tick) begin
            if (!act_q) begin
                act_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == ONE) begin
                    act_q  <= 1'b0;
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign cnt    = cnt_q;
    assign busy   = busy_q;
    assign active = act_q;

    // R5
    launch_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !act_q);
    // R5
    rise_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> busy_q);
endmodule

// File: rtl/oneshot_delay_pulse.sv
// Top of the triggered delayed one-shot generator.
// Holds the run flag and the configuration registers, which can be written
// only while stopped. Chains the delay and width channels and drives the
// output pin with polarity and software override.
// Assumes: strobes are single-cycle; stop wins over start.
module oneshot_delay_pulse #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig_in,
    input  logic [1:0]       edge_sel,
    input  logic             start_stb,
    input  logic             stop_stb,
    input  logic             sw_kick,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             cfg_act_low,
    input  logic             out_en,
    input  logic             sw_level,
    output logic             done_stb,
    output logic             running,
    output logic [CNT_W-1:0] delay_cnt,
    output logic [CNT_W-1:0] width_cnt,
    output logic             pulse_out
);
    logic             run_q;
    logic [CNT_W-1:0] cfg_delay_q;
    logic [CNT_W-1:0] cfg_width_q;
    logic             cfg_act_low_q;
    logic             en_w;
    logic             arm_w;
    logic             ext_evt;
    logic             dly_busy;
    logic             dly_term;
    logic             wid_busy;
    logic             wid_act;

    // Channel enable drops in the stop cycle; arm needs start without stop
    always_comb begin
        en_w  = run_q && !stop_stb;
        arm_w = start_stb && !stop_stb;
    end

    // Run flag shared by both channels
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 1'b0;
        else if (stop_stb) run_q <= 1'b0;
        else if (start_stb) run_q <= 1'b1;
    end

    // Configuration registers, locked while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_delay_q   <= '0;
            cfg_width_q   <= '0;
            cfg_act_low_q <= 1'b0;
        end else if (cfg_we && !run_q) begin
            cfg_delay_q   <= cfg_delay;
            cfg_width_q   <= cfg_width;
            cfg_act_low_q <= cfg_act_low;
        end
    end

    osp_trig_sync #(.STAGES(SYNC_STAGES)) trig_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .edge_sel (osp_pkg::edge_sel_e'(edge_sel)),
        .trig_evt (ext_evt)
    );

    osp_delay_chan #(.CNT_W(CNT_W)) dly_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .arm      (arm_w),
        .tick     (tick),
        .trig_req (ext_evt || sw_kick),
        .blocked  (wid_busy),
        .load_val (cfg_delay_q),
        .cnt      (delay_cnt),
        .busy     (dly_busy),
        .term     (dly_term),
        .done_stb (done_stb)
    );

    osp_width_chan #(.CNT_W(CNT_W)) wid_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .arm      (arm_w),
        .tick     (tick),
        .launch   (dly_term),
        .load_val (cfg_width_q),
        .cnt      (width_cnt),
        .busy     (wid_busy),
        .active   (wid_act)
    );

    // Output pin: polarity applied to pulse state, or software level
    always_comb begin
        pulse_out = out_en ? (wid_act ^ cfg_act_low_q) : sw_level;
    end

    assign running = run_q;

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb || (!run_q && !start_stb))
            |=> ($stable(delay_cnt) && $stable(width_cnt) && $stable(wid_act)));
    // R8
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> ($stable(cfg_delay_q) && $stable(cfg_width_q) && $stable(cfg_act_low_q)));
    // R6
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dly_busy && wid_busy));
endmodule

// File: tb/oneshot_delay_pulse_tb_top.sv
`timescale 1ns/1ps
module oneshot_delay_pulse_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b1;
    logic         trig_in = 1'b0;
    logic [1:0]   edge_sel = 2'b01;
    logic         start_stb = 1'b0;
    logic         stop_stb = 1'b0;
    logic         sw_kick = 1'b0;
    logic         cfg_we = 1'b0;
    logic [W-1:0] cfg_delay = '0;
    logic [W-1:0] cfg_width = '0;
    logic         cfg_act_low = 1'b0;
    logic         out_en = 1'b1;
    logic         sw_level = 1'b0;
    logic         done_stb;
    logic         running;
    logic [W-1:0] delay_cnt;
    logic [W-1:0] width_cnt;
    logic         pulse_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    oneshot_delay_pulse #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig_in),
        .edge_sel(edge_sel), .start_stb(start_stb), .stop_stb(stop_stb),
        .sw_kick(sw_kick), .cfg_we(cfg_we), .cfg_delay(cfg_delay),
        .cfg_width(cfg_width), .cfg_act_low(cfg_act_low), .out_en(out_en),
        .sw_level(sw_level), .done_stb(done_stb), .running(running),
        .delay_cnt(delay_cnt), .width_cnt(width_cnt), .pulse_out(pulse_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe_stop();
        stop_stb = 1'b1; @(negedge clk); stop_stb = 1'b0;
    endtask

    task automatic strobe_start();
        start_stb = 1'b1; @(negedge clk); start_stb = 1'b0;
    endtask

    // Stop, write configuration, re-arm
    task automatic setup(input int d, input int w, input logic al);
        strobe_stop();
        cfg_we = 1'b1; cfg_delay = W'(d); cfg_width = W'(w); cfg_act_low = al;
        @(negedge clk); cfg_we = 1'b0;
        strobe_start();
    endtask

    // One software-started shot, timed in cycles after the kick edge
    task automatic shot(input int d, input int w, input logic al, input int rk, input string tag);
        int fd = -1;
        int nd = 0;
        int fa = -1;
        int na = 0;
        chk({tag, " R9 idle level"}, int'(pulse_out), int'(al));
        sw_kick = 1'b1;
        @(negedge clk);
        sw_kick = 1'b0;
        for (int c = 1; c <= d + w + 8; c++) begin
            if (done_stb) begin nd++; if (fd < 0) fd = c; end
            if (pulse_out !== al) begin na++; if (fa < 0) fa = c; end
            sw_kick = (c == rk);
            @(negedge clk);
        end
        sw_kick = 1'b0;
        chk({tag, " R4 done cycle"}, fd, d + 2);
        chk({tag, " R4 done count"}, nd, 1);
        chk({tag, " R5 first active"}, fa, (w == 0) ? -1 : d + 3);
        chk({tag, " R5 active length"}, na, w);
    endtask

    // One external edge in a given select mode
    task automatic edge_try(input logic [1:0] sel, input logic rising, input int fire);
        int nd = 0;
        strobe_stop();
        edge_sel = sel;
        trig_in = ~rising;
        repeat (5) @(negedge clk);
        strobe_start();
        trig_in = rising;
        @(negedge clk);
        chk("R2 no load after 1 edge", int'(delay_cnt), 0);
        @(negedge clk);
        chk("R2 no load after 2 edges", int'(delay_cnt), 0);
        @(negedge clk);
        chk("R2 load after 3 edges", int'(delay_cnt), fire ? 5 : 0);
        for (int c = 0; c < 20; c++) begin
            if (done_stb) nd++;
            @(negedge clk);
        end
        chk("R2 edge mode done count", nd, fire);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int dc;
        int wc;
        int bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 running", int'(running), 0);
        chk("R1 done", int'(done_stb), 0);
        chk("R1 delay_cnt", int'(delay_cnt), 0);
        chk("R1 width_cnt", int'(width_cnt), 0);
        chk("R1 pulse_out", int'(pulse_out), 0);

        // R1 start arms but nothing counts without a trigger
        setup(4, 2, 1'b0);
        chk("R7 running after start", int'(running), 1);
        bad = 0;
        for (int c = 0; c < 10; c++) begin
            if (done_stb || delay_cnt != 0) bad++;
            @(negedge clk);
        end
        chk("R1 waits for trigger", bad, 0);

        // R3 R4 R5 R9 sweep over delay, width and polarity
        for (int al = 0; al < 2; al++)
            for (int d = 0; d <= 4; d++)
                for (int w = 0; w <= 3; w++) begin
                    setup(d, w, al[0]);
                    shot(d, w, al[0], -1, "R3 sweep");
                end

        // R6 kick on the delay terminal edge, then on the width launch edge
        setup(3, 4, 1'b0);
        shot(3, 4, 1'b0, 4, "R6 kick at terminal");
        shot(3, 4, 1'b0, 5, "R6 kick at launch");
        shot(3, 4, 1'b0, 2, "R6 kick during delay");
        shot(3, 4, 1'b0, 7, "R6 kick during width");

        // R8 configuration writes ignored while running
        setup(3, 2, 1'b0);
        cfg_we = 1'b1; cfg_delay = 16'd7; cfg_width = 16'd5; cfg_act_low = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
        shot(3, 2, 1'b0, -1, "R8 locked cfg");

        // R3 tick low holds the delay count
        setup(10, 2, 1'b0);
        sw_kick = 1'b1; @(negedge clk); sw_kick = 1'b0;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        dc = int'(delay_cnt);
        repeat (5) @(negedge clk);
        chk("R3 hold with tick low", int'(delay_cnt), dc);
        chk("R3 value before hold", dc, 7);
        tick = 1'b1;
        @(negedge clk);
        chk("R3 resumes on tick", int'(delay_cnt), 6);
        repeat (20) @(negedge clk);

        // R7 stop in mid-pulse freezes counters and output level
        setup(2, 20, 1'b0);
        sw_kick = 1'b1; @(negedge clk); sw_kick = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 active mid-pulse", int'(pulse_out), 1);
        strobe_stop();
        dc = int'(delay_cnt);
        wc = int'(width_cnt);
        sw_kick = 1'b1; @(negedge clk); sw_kick = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7 running cleared", int'(running), 0);
        chk("R7 delay_cnt held", int'(delay_cnt), dc);
        chk("R7 width_cnt held", int'(width_cnt), wc);
        chk("R7 width_cnt mid value", wc, 18);
        chk("R7 output level held", int'(pulse_out), 1);
        strobe_start();
        chk("R7 start clears pulse", int'(pulse_out), 0);
        chk("R7 counters kept on start", int'(width_cnt), wc);

        // R7 start and stop together: stop wins
        start_stb = 1'b1; stop_stb = 1'b1;
        @(negedge clk);
        start_stb = 1'b0; stop_stb = 1'b0;
        chk("R7 stop wins over start", int'(running), 0);

        // R10 software level override during a shot
        setup(0, 3, 1'b0);
        out_en = 1'b0;
        for (int lv = 0; lv < 2; lv++) begin
            sw_level = lv[0];
            bad = 0;
            sw_kick = 1'b1; @(negedge clk); sw_kick = 1'b0;
            for (int c = 0; c < 10; c++) begin
                if (pulse_out !== lv[0]) bad++;
                @(negedge clk);
            end
            chk("R10 override level", bad, 0);
        end
        out_en = 1'b1;
        sw_level = 1'b0;

        // R2 edge selection: falling, rising, both, reserved
        cfg_we = 1'b0;
        strobe_stop();
        cfg_we = 1'b1; cfg_delay = 16'd5; cfg_width = 16'd1; cfg_act_low = 1'b0;
        @(negedge clk); cfg_we = 1'b0;
        edge_try(2'b00, 1'b0, 1);
        edge_try(2'b00, 1'b1, 0);
        edge_try(2'b01, 1'b1, 1);
        edge_try(2'b01, 1'b0, 0);
        edge_try(2'b10, 1'b1, 1);
        edge_try(2'b10, 1'b0, 1);
        edge_try(2'b11, 1'b0, 1);
        edge_try(2'b11, 1'b1, 0);

        // R6 edge ignored while stopped
        strobe_stop();
        edge_sel = 2'b01;
        trig_in = 1'b0;
        repeat (5) @(negedge clk);
        trig_in = 1'b1;
        bad = 0;
        for (int c = 0; c < 15; c++) begin
            if (done_stb || delay_cnt != 0) bad++;
            @(negedge clk);
        end
        chk("R6 edge while stopped", bad, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule